// File: doc/BRIEF.md
# Bit-Parallel Folded Distributed-Arithmetic FIR Filter

This block is a linear-phase FIR filter with an even number of taps. Its coefficients are mirror-symmetric and fixed when the block is built. It accepts one sample per clock and returns one filtered sample per clock. The filter uses no multipliers.

Each pair of samples that share a coefficient is added first, so only half the taps carry coefficient logic. The folded taps are split into groups of five. For each group and for each bit position of the pre-added samples there is one small partial-sum unit. Each unit holds a 16-entry table of sums of four coefficients and uses one conditional add for the fifth. All group/bit results are shifted to their binary weight and reduced by a registered binary adder tree. The top bit slice carries negative weight.

A sample is written with `in_valid` high. Its filtered result appears a fixed number of cycles later with `out_valid` high. Cycles with `in_valid` low do not advance the sample history.

Top module: `da_fir`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid` is 0 and `y` is 0. Until the first sample is accepted, `y` stays 0.
- R2: For each accepted sample, `y` equals the sum over taps j = 0..NTAPS-1 of h[j]·x[n-j]. Here x[n-j] is the j-th most recent accepted sample, with zeros before reset. h[j] is the coefficient at index min(j, NTAPS-1-j).
- R3: Coefficient k is the signed CW-bit value at bits [k·CW +: CW] of `COEFS`, for k = 0..NTAPS/2-1.
- R4: `out_valid` follows `in_valid` delayed by exactly LAT = 3 + ceil(log2(ceil((NTAPS/2)/5)·(XW+1))) clocks, and `y` is valid in that same cycle. With in_valid held high, a new result arrives every clock.
- R5: A cycle with `in_valid` low does not enter the history. `x_in` in that cycle has no effect on any later output.
- R6: After LAT cycles with no accepted sample, `y` holds its value.
- R7: Full-scale inputs (the most negative and the most positive XW-bit values, alone or alternating) give exact results. `y` is a signed two's-complement value of XW + CW + ceil(log2(5·ceil((NTAPS/2)/5))) + 2 bits.
- R8: A single accepted value of 1 followed by zeros produces h[0], h[1], ..., h[NTAPS-1] on consecutive outputs. This also holds when the folded tap count is not a multiple of five.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept `x_in` this cycle |
| x_in | input | XW | Signed input sample |
| out_valid | output | 1 | `y` holds a new result |
| y | output | AW | Signed filter output |

## Verification
The bound checker watches four properties on every clock:
- `out_valid` trails `in_valid` by the fixed latency.
- The output stays still once the pipeline has drained.
- The output is zero before the first sample is accepted.
- The outputs are cleared during reset.

The arithmetic itself is shown only by the bench scenarios, which compare every result against a direct convolution. These scenarios cover an impulse, random streams, full-scale and alternating extremes, and gapped input. Together they exercise the negative-weight top slice, the zero padding of the last group, and the ignoring of unaccepted samples.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    localparam int GRP_TAPS = 5;
    localparam int TBL_BITS = GRP_TAPS - 1;

    function automatic int n_groups(input int nf);
        return (nf + GRP_TAPS - 1) / GRP_TAPS;
    endfunction

    // Deterministic non-trivial coefficient set used when none is supplied.
    function automatic logic [4095:0] demo_coefs(input int nf, input int cw);
        logic [4095:0] r;
        logic [4095:0] mask;
        int v;
        r    = '0;
        mask = (4096'(1) << cw) - 4096'(1);
        for (int k = 0; k < nf; k++) begin
            v = ((k * 29 + 7) % (1 << (cw - 1))) - (1 << (cw - 2));
            r = r | ((4096'(v) & mask) << (k * cw));
        end
        return r;
    endfunction

endpackage

// File: rtl/da_fold.sv
module da_fold #(
    parameter int NTAPS = 70,
    parameter int XW    = 13,
    localparam int NF   = NTAPS / 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [XW-1:0]   x_in,
    output logic [NF-1:0][XW:0]    pairs
);
    logic signed [XW-1:0] hist_q [NTAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAPS; i++) hist_q[i] <= '0;
        end else if (in_valid) begin
            hist_q[0] <= x_in;
            for (int i = 1; i < NTAPS; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pairs <= '0;
        end else begin
            for (int k = 0; k < NF; k++)
                pairs[k] <= (XW+1)'(hist_q[k]) + (XW+1)'(hist_q[NTAPS-1-k]);
        end
    end
endmodule

// File: rtl/da_slice_unit.sv
module da_slice_unit #(
    parameter int CW = 12,
    parameter logic [5*CW-1:0] GC = '0,
    localparam int UW = CW + 3
) (
    input  logic [4:0]            sel,
    output logic signed [UW-1:0]  psum
);
    function automatic logic [16*UW-1:0] build_tbl();
        logic [16*UW-1:0] t;
        logic signed [UW-1:0] s;
        t = '0;
        for (int a = 0; a < 16; a++) begin
            s = '0;
            for (int k = 0; k < 4; k++)
                if (a[k]) s = s + UW'($signed(GC[k*CW +: CW]));
            t[a*UW +: UW] = s;
        end
        return t;
    endfunction

    localparam logic [16*UW-1:0] TBL = build_tbl();
    localparam logic signed [UW-1:0] C_LAST = UW'($signed(GC[4*CW +: CW]));

    logic signed [UW-1:0] base;
    always_comb begin
        base = $signed(TBL[sel[3:0]*UW +: UW]);
        psum = sel[4] ? base + C_LAST : base;
    end
endmodule

// File: rtl/da_tree.sv
module da_tree #(
    parameter int N = 8,
    parameter int W = 32,
    localparam int LEVELS = $clog2(N),
    localparam int NP = 1 << LEVELS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0][W-1:0]  leaves,
    output logic signed [W-1:0]  root
);
    logic signed [W-1:0] node [2*NP-1];

    for (genvar j = 0; j < NP; j++) begin : g_leaf
        if (j < N) begin : g_real
            always_ff @(posedge clk)
                node[NP-1+j] <= rst ? '0 : $signed(leaves[j]);
        end else begin : g_pad
            always_ff @(posedge clk)
                node[NP-1+j] <= '0;
        end
    end

    for (genvar i = 0; i < NP - 1; i++) begin : g_add
        always_ff @(posedge clk)
            node[i] <= rst ? '0 : node[2*i+1] + node[2*i+2];
    end

    assign root = node[0];
endmodule

// File: rtl/da_fir.sv
module da_fir
    import da_fir_pkg::*;
#(
    parameter int NTAPS = 70,
    parameter int XW    = 13,
    parameter int CW    = 12,
    parameter logic [(NTAPS/2)*CW-1:0] COEFS =
        ((NTAPS/2)*CW)'(da_fir_pkg::demo_coefs(NTAPS/2, CW)),
    localparam int NF     = NTAPS / 2,
    localparam int NG     = n_groups(NF),
    localparam int NS     = XW + 1,
    localparam int NT     = NG * NS,
    localparam int LEVELS = $clog2(NT),
    localparam int LAT    = LEVELS + 3,
    localparam int AW     = XW + CW + $clog2(NG * GRP_TAPS) + 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic signed [XW-1:0]  x_in,
    output logic                  out_valid,
    output logic signed [AW-1:0]  y
);
    localparam int UW = CW + 3;
    localparam logic [NG*GRP_TAPS*CW-1:0] CPAD = (NG*GRP_TAPS*CW)'(COEFS);

    logic [NF-1:0][XW:0]   pairs;
    logic [NT-1:0][AW-1:0] terms;
    logic [LAT-1:0]        vq;

    da_fold #(.NTAPS(NTAPS), .XW(XW)) u_fold (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in), .pairs(pairs)
    );

    for (genvar g = 0; g < NG; g++) begin : g_grp
        for (genvar b = 0; b < NS; b++) begin : g_bit
            logic [4:0]           sel;
            logic signed [UW-1:0] psum;
            logic signed [AW-1:0] wide;

            for (genvar t = 0; t < GRP_TAPS; t++) begin : g_tap
                if (g*GRP_TAPS + t < NF) begin : g_use
                    assign sel[t] = pairs[g*GRP_TAPS + t][b];
                end else begin : g_zero
                    assign sel[t] = 1'b0;
                end
            end

            da_slice_unit #(
                .CW(CW),
                .GC(CPAD[g*GRP_TAPS*CW +: GRP_TAPS*CW])
            ) u_unit (.sel(sel), .psum(psum));

            assign wide = AW'(psum);
            if (b == NS - 1) begin : g_neg
                assign terms[g*NS + b] = -(wide <<< b);
            end else begin : g_pos
                assign terms[g*NS + b] = wide <<< b;
            end
        end
    end

    da_tree #(.N(NT), .W(AW)) u_tree (
        .clk(clk), .rst(rst), .leaves(terms), .root(y)
    );

    always_ff @(posedge clk) begin
        if (rst) vq <= '0;
        else     vq <= {vq[LAT-2:0], in_valid};
    end

    assign out_valid = vq[LAT-1];
endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk #(
    parameter int LAT = 8,
    parameter int AW  = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic signed [AW-1:0] y
);
    logic [LAT-1:0] vshadow;
    int unsigned    quiet;
    logic           seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            vshadow <= '0;
            quiet   <= 0;
            seen    <= 1'b0;
        end else begin
            vshadow <= {vshadow[LAT-2:0], in_valid};
            seen    <= seen | in_valid;
            if (in_valid)                  quiet <= 0;
            else if (quiet < unsigned'(LAT)) quiet <= quiet + 1;
        end
    end

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && y == '0));

    // R1
    a_r1_zero_before_first: assert property (@(posedge clk) disable iff (rst)
        !seen |-> y == '0);

    // R4
    a_r4_valid_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == vshadow[LAT-1]);

    // R6
    a_r6_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (quiet >= unsigned'(LAT)) |-> $stable(y));
endmodule

bind da_fir da_fir_chk #(.LAT(LAT), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid), .y(y)
);

// File: tb/test_da_fir.sv
module test_da_fir;
    localparam int NTAPS = 14;
    localparam int XW    = 8;
    localparam int CW    = 8;
    localparam int NF    = NTAPS / 2;
    localparam int NGRP  = (NF + 4) / 5;
    localparam int LAT   = 3 + $clog2(NGRP * (XW + 1));
    localparam int AW    = XW + CW + $clog2(5 * NGRP) + 2;
    localparam logic [NF*CW-1:0] BC =
        {8'hFD, 8'd90, 8'hC0, 8'd5, 8'd127, 8'h80, 8'd17};

    int coef [NF] = '{17, -128, 127, 5, -64, 90, -3};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [XW-1:0] x_in = '0;
    logic                 out_valid;
    logic signed [AW-1:0] y;

    int errs = 0;
    int checks = 0;
    int hist [NTAPS];
    bit qv [$];
    int qy [$];
    string qt [$];
    bit done = 0;

    always #10 clk = ~clk;

    da_fir #(.NTAPS(NTAPS), .XW(XW), .CW(CW), .COEFS(BC)) i_da_fir (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
        .out_valid(out_valid), .y(y)
    );

    function automatic int hcoef(input int j);
        return (j < NF) ? coef[j] : coef[NTAPS-1-j];
    endfunction

    task automatic chk(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic step(input bit v, input int x, input string tag);
        int e;
        @(negedge clk);
        if (qv.size() == LAT) begin
            bit ev;
            int ey;
            string et;
            ev = qv.pop_front();
            ey = qy.pop_front();
            et = qt.pop_front();
            chk("R4 out_valid timing", int'(out_valid), int'(ev));
            if (ev) chk(et, int'($signed(y)), ey);
        end else begin
            chk("R1 out_valid low during fill", int'(out_valid), 0);
        end
        in_valid = v;
        x_in     = XW'(x);
        e = 0;
        if (v) begin
            for (int i = NTAPS - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = x;
            for (int j = 0; j < NTAPS; j++) e += hcoef(j) * hist[j];
        end
        qv.push_back(v);
        qy.push_back(e);
        qt.push_back(tag);
    endtask

    task automatic drain();
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 0, "drain");
    endtask

    initial begin
        #(20 * 100000);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NTAPS; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", int'(out_valid), 0);
        chk("R1 reset y", int'($signed(y)), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 y after reset", int'($signed(y)), 0);
        // R8 impulse: outputs walk through h[0..NTAPS-1], R3 packing
        step(1'b1, 1, "R8 impulse");
        for (int i = 0; i < NTAPS + 2; i++) step(1'b1, 0, "R8 impulse");
        drain();
        // R6 quiet: output must hold
        begin
            int held;
            held = int'($signed(y));
            repeat (4) @(negedge clk);
            chk("R6 y holds when idle", int'($signed(y)), held);
        end
        // R2 random continuous stream, one result per clock
        for (int i = 0; i < 300; i++)
            step(1'b1, int'($urandom_range(0, 255)) - 128, "R2 random stream");
        // R7 full-scale extremes
        for (int i = 0; i < 20; i++) step(1'b1, -128, "R7 all min");
        for (int i = 0; i < 20; i++) step(1'b1, 127, "R7 all max");
        for (int i = 0; i < 30; i++) step(1'b1, (i % 2) ? 127 : -128, "R7 alternating");
        for (int i = 0; i < 30; i++) step(1'b1, (i % 3 == 0) ? -128 : 127, "R7 mixed");
        // R5 gapped input with junk on idle cycles
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 1) == 1)
                step(1'b1, int'($urandom_range(0, 255)) - 128, "R5 gapped stream");
            else
                step(1'b0, int'($urandom_range(0, 255)) - 128, "R5 ignored");
        end
        drain();
        // R8 second impulse of negative sign after gaps
        step(1'b1, -1, "R8 negative impulse");
        for (int i = 0; i < NTAPS; i++) step(1'b1, 0, "R8 negative impulse");
        drain();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule